// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block keeps the low two bits of a burst access and steps them through a four-beat burst. A burst begins when a load strobe captures the low address bits as the start offset. After that, each sampled-low advance input moves the burst one beat forward. The offset reached at each beat depends on the burst order in force when the burst was loaded. That order is either linear (start plus beat, wrapping modulo four) or interleaved (start XOR beat).

There are two active-low load strobes. The processor strobe takes effect only while the primary chip enable is low, and it wins when both strobes are active. The controller strobe is not gated by chip enable. The block reports the current offset and the beat number, and it also shows which strobe started the burst so that the priority can be observed. The upper address bits, the storage array and the data paths belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state: `burst_off` is 0, `beat_idx` is 0 and `burst_src` is 0.
- R2: A rising edge with `ld_ctrl_n` low and no recognised processor load loads `addr_lo` as the start. After that edge, `burst_off` equals the loaded value, `beat_idx` is 0 and `burst_src` is 0.
- R3: A rising edge with `ld_proc_n` low and `ce1_n` low loads `addr_lo` as the start. After that edge, `beat_idx` is 0 and `burst_src` is 1.
- R4: When `ce1_n` is high, `ld_proc_n` has no effect. If `ld_ctrl_n` is also high, the edge behaves as a non-load edge.
- R5: When both strobes are low and `ce1_n` is low, the load is credited to the processor strobe (`burst_src` = 1).
- R6: On a non-load edge with `adv_n` low, `beat_idx` goes up by one and wraps from 3 back to 0.
- R7: On a non-load edge with `adv_n` high, `burst_off`, `beat_idx` and `burst_src` keep their values.
- R8: When `order_sel` was 0 at load time (linear), `burst_off` = (start + `beat_idx`) mod 4. A start of 1 gives 1,2,3,0.
- R9: When `order_sel` was 1 at load time (interleaved), `burst_off` = start XOR `beat_idx`. A start of 1 gives 1,0,3,2.
- R10: `order_sel` is sampled only on load edges. Changing it during a burst does not change the offsets of that burst.
- R11: When a load and a low `adv_n` fall on the same edge, the load wins and `beat_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_lo | input | 2 | Low address bits that form the start offset |
| ld_proc_n | input | 1 | Processor load strobe, active low, gated by `ce1_n` |
| ld_ctrl_n | input | 1 | Controller load strobe, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | Burst order strap: 1 selects interleaved, 0 selects linear |
| burst_off | output | 2 | Current burst offset |
| beat_idx | output | 2 | Beat number within the burst (0 to 3) |
| burst_src | output | 1 | 1 if the current burst was loaded by the processor strobe |

## Verification
A load and an advance can arrive on the same edge. The processor strobe and the controller strobe can also be low together while chip enable decides whether the processor strobe counts. Random stimulus drives all of these inputs independently, so these overlaps occur often, and directed cycles force each one explicitly. For every edge the bench model picks the winner: processor before controller, and any load before advance. It then compares the offset, beat and source against that choice. A mid-burst flip of the order strap is judged by checking that the offsets already being produced do not change.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int CNT_W = 2;
    localparam int BEATS = 1 << CNT_W;

    typedef logic [CNT_W-1:0] offs_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } order_t;

    typedef enum logic {
        SRC_CTRL = 1'b0,
        SRC_PROC = 1'b1
    } src_t;

    typedef struct packed {
        offs_t  start;
        offs_t  beat;
        order_t order;
        src_t   src;
    } burst_state_t;

    localparam burst_state_t STATE_RST = '{start: '0, beat: '0, order: ORD_INTLV, src: SRC_CTRL};

    function automatic offs_t map_offset(input offs_t start, input offs_t beat, input order_t ord);
        offs_t res;
        if (ord == ORD_INTLV) res = start ^ beat;
        else                  res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_load_arb.sv
module burst_load_arb (
    input  logic ld_proc_n,
    input  logic ld_ctrl_n,
    input  logic ce1_n,
    output logic load,
    output burst_pkg::src_t src
);
    import burst_pkg::*;

    logic proc_hit;
    logic ctrl_hit;

    always_comb begin
        proc_hit = !ld_proc_n && !ce1_n;
        ctrl_hit = !ld_ctrl_n;
        load     = proc_hit || ctrl_hit;
        src      = proc_hit ? SRC_PROC : SRC_CTRL;
    end
endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    adv_n,
    input  burst_pkg::offs_t        start_in,
    input  burst_pkg::order_t       order_in,
    input  burst_pkg::src_t         src_in,
    output burst_pkg::burst_state_t state
);
    import burst_pkg::*;

    burst_state_t nxt;

    always_comb begin
        nxt = state;
        if (load) begin
            nxt.start = start_in;
            nxt.beat  = '0;
            nxt.order = order_in;
            nxt.src   = src_in;
        end else if (!adv_n) begin
            nxt.beat = state.beat + offs_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= STATE_RST;
        else     state <= nxt;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map (
    input  burst_pkg::burst_state_t state,
    output burst_pkg::offs_t        off
);
    import burst_pkg::*;

    always_comb off = map_offset(state.start, state.beat, state.order);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] addr_lo,
    input  logic             ld_proc_n,
    input  logic             ld_ctrl_n,
    input  logic             ce1_n,
    input  logic             adv_n,
    input  logic             order_sel,
    output logic [CNT_W-1:0] burst_off,
    output logic [CNT_W-1:0] beat_idx,
    output logic             burst_src
);
    logic         load;
    src_t         src;
    burst_state_t state;
    offs_t        off;

    burst_load_arb u_arb (
        .ld_proc_n (ld_proc_n),
        .ld_ctrl_n (ld_ctrl_n),
        .ce1_n     (ce1_n),
        .load      (load),
        .src       (src)
    );

    burst_step_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv_n    (adv_n),
        .start_in (addr_lo),
        .order_in (order_sel ? ORD_INTLV : ORD_LINEAR),
        .src_in   (src),
        .state    (state)
    );

    burst_order_map u_map (
        .state (state),
        .off   (off)
    );

    assign burst_off = off;
    assign beat_idx  = state.beat;
    assign burst_src = (state.src == SRC_PROC);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] addr_lo,
    input logic             ld_proc_n,
    input logic             ld_ctrl_n,
    input logic             ce1_n,
    input logic             adv_n,
    input logic             order_sel,
    input logic [CNT_W-1:0] burst_off,
    input logic [CNT_W-1:0] beat_idx,
    input logic             burst_src
);
    logic p_ld;
    logic c_ld;
    logic any_ld;
    assign p_ld   = !ld_proc_n && !ce1_n;
    assign c_ld   = !ld_ctrl_n && !p_ld;
    assign any_ld = p_ld || c_ld;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (burst_off == '0 && beat_idx == '0 && !burst_src));

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        c_ld |=> (burst_off == $past(addr_lo) && beat_idx == '0 && !burst_src));

    // R3
    proc_load_chk: assert property (@(posedge clk) disable iff (rst)
        p_ld |=> (burst_off == $past(addr_lo) && beat_idx == '0 && burst_src));

    // R6
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_ld && !adv_n) |=> (beat_idx == $past(beat_idx) + 2'd1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_ld && adv_n) |=> ($stable(burst_off) && $stable(beat_idx) && $stable(burst_src)));

    // R10
    order_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_ld && !adv_n) |=> (burst_off == ($past(burst_off) ^ $past(beat_idx) ^ beat_idx)
                                 || burst_off == $past(burst_off) + 2'd1));
endmodule

bind burst_addr_gen burst_addr_gen_chk u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr_lo;
    logic       ld_proc_n, ld_ctrl_n, ce1_n, adv_n, order_sel;
    logic [1:0] burst_off, beat_idx;
    logic       burst_src;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_start, m_beat;
    logic       m_ord, m_src;

    always #5 clk = ~clk;

    burst_addr_gen u_dut (
        .clk(clk), .rst(rst), .addr_lo(addr_lo), .ld_proc_n(ld_proc_n),
        .ld_ctrl_n(ld_ctrl_n), .ce1_n(ce1_n), .adv_n(adv_n), .order_sel(order_sel),
        .burst_off(burst_off), .beat_idx(beat_idx), .burst_src(burst_src)
    );

    function automatic logic [1:0] exp_off(input logic [1:0] s, input logic [1:0] b, input logic ord);
        return ord ? (s ^ b) : (s + b);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] a, input logic lp, input logic lc,
                       input logic ce, input logic adv, input logic ord);
        logic pl, ld;
        string tb_tag;
        addr_lo = a; ld_proc_n = lp; ld_ctrl_n = lc; ce1_n = ce; adv_n = adv; order_sel = ord;
        pl = !lp && !ce;
        ld = pl || !lc;
        if (ld && !adv)        tb_tag = "R11";
        else if (pl && !lc)    tb_tag = "R5";
        else if (pl)           tb_tag = "R3";
        else if (ld && !lp)    tb_tag = "R4";
        else if (ld)           tb_tag = "R2";
        else if (!lp)          tb_tag = "R4";
        else if (!adv)         tb_tag = "R6";
        else                   tb_tag = "R7";
        @(posedge clk);
        if (ld) begin
            m_start = a; m_beat = 2'd0; m_ord = ord; m_src = pl;
        end else if (!adv) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        chk(tb_tag, beat_idx, m_beat);
        chk(tb_tag, burst_src, m_src);
        chk(m_ord ? "R9" : "R8", burst_off, exp_off(m_start, m_beat, m_ord));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1'b1; addr_lo = 2'd3; ld_proc_n = 1'b1; ld_ctrl_n = 1'b0;
        ce1_n = 1'b0; adv_n = 1'b0; order_sel = 1'b0;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1", burst_off, 0);
        chk("R1", beat_idx, 0);
        chk("R1", burst_src, 0);
        rst = 1'b0;
        m_start = 2'd0; m_beat = 2'd0; m_ord = 1'b1; m_src = 1'b0;

        // R8 linear from start 1: 1,2,3,0 then wrap (R6)
        cyc(2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6", beat_idx, 0);
        chk("R8", burst_off, 1);

        // R9 interleaved from start 2 with mid-burst strap flip (R10)
        cyc(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", burst_off, 3);
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", burst_off, 0);
        cyc(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9", burst_off, 1);
        // interleaved from start 1 differs from linear at beat 1
        cyc(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9", burst_off, 0);

        // R5 both strobes, chip enabled: processor credited
        cyc(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5", burst_src, 1);
        // R4 processor strobe with chip disabled, controller idle: hold
        cyc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R4", burst_off, 3);
        // R4 processor ignored, controller loads
        cyc(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R4", burst_src, 0);
        // R11 load beats advance
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11", beat_idx, 0);
        chk("R11", burst_off, 1);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc(2'($urandom), (r[0] & r[1]), ($urandom % 4) != 0, r[2] & r[3],
                ($urandom % 3) == 0, 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule